// File: doc/BRIEF.md
# PCM frame sync tracker

This block follows the frame-sync strobe of a PCM highway against its bit clock. It learns the frame length from the spacing of rising edges on the strobe. It declares lock once that spacing repeats, and it reports loss of lock when an edge comes early or fails to come at the learned interval. While locked it gives the current bit and time-slot position inside the frame. It also gives three one-clock frame-start markers: one for the receive direction, one for the transmit direction and one for the control direction. Each marker can be moved later by its own programmed number of bit times.

The bit clock runs at the data rate or at twice the data rate. In double-rate operation two clock cycles make one bit time. The strobe is sampled once per bit time. A rate-mode input sets the longest frame that is accepted, so the frame length, and with it the data rate, can move in whole-bit steps below that limit. The block has no data path. All of its pins are plain control and status signals, so no valid/ready handshake and no back-pressure apply.

Top module: `pcm_sync_tracker`

## Requirements
- R1: While reset is asserted and directly after it, sync_lost is 1, all three frame-start markers are 0, and bit_cnt and slot_cnt are 0.
- R2: With dbl_rate=0 every clock cycle is one bit time. With dbl_rate=1 every second clock cycle is one bit time. fsync is sampled once per bit time, and all counting is in bit times.
- R3: A sync edge is a bit time whose fsync sample is 1 while the previous sample was 0. That bit is position 0 of the frame. Position p is reported as bit_cnt = p mod 8 and slot_cnt = p / 8, one clock after the bit is sampled.
- R4: The first sync edge starts a measurement. The second stores the spacing in bit times as the frame length. A third edge at that same spacing sets sync_lost to 0. Pulses one bit time long and low gaps one bit time long are both accepted.
- R5: The longest accepted frame length is 256 bits for mode 0, 512 bits for mode 1, and 1024 bits for modes 2 and 3. A longer measured spacing is not stored, and the search starts again from that edge.
- R6: While locked, a sync edge that arrives before the stored length has elapsed sets sync_lost to 1.
- R7: While locked, if no sync edge is sampled at position equal to the stored length, sync_lost becomes 1 at that bit. An edge that comes later does not restore lock.
- R8: After a loss, lock is regained only through the R4 sequence. An early edge counts as the first edge of the new search.
- R9: While locked, sof_in, sof_out and sof_ctl each pulse for one clock when the frame position equals off_in, off_out or off_ctl. With an offset of 0 the pulse marks the sync-edge bit itself. An offset at or above the frame length gives no pulse.
- R10: No frame-start marker pulses while sync_lost is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync strobe |
| mode | input | 2 | Rate mode, sets the longest accepted frame |
| dbl_rate | input | 1 | 1: clock is twice the bit rate |
| off_in | input | 11 | Receive frame-start offset in bit times |
| off_out | input | 11 | Transmit frame-start offset in bit times |
| off_ctl | input | 11 | Control frame-start offset in bit times |
| sync_lost | output | 1 | 0 when locked, 1 when searching or lost |
| bit_cnt | output | 3 | Bit position inside the current time slot |
| slot_cnt | output | 8 | Time-slot index inside the frame |
| sof_in | output | 1 | Receive frame-start pulse |
| sof_out | output | 1 | Transmit frame-start pulse |
| sof_ctl | output | 1 | Control frame-start pulse |

## Verification
The hardest case to reach from the ports is a loss of lock that must be told apart from a fresh search. An early edge must start the new measurement at once. A missing edge must drop lock at exactly the due bit, and a late edge arriving after it must not rescue the lock. The stimulus first locks the tracker with regular frames. It then cuts one frame short, or adds idle bit times after a frame, and samples sync_lost at the due bit and after each of the following edges. The length limits are reached by running frame spacings of exactly 256 bits and of 257 and 300 bits under different modes.

// File: rtl/pcm_sync_pkg.sv
package pcm_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_LOCK   = 2'd3
  } trk_state_e;

  localparam int NUM_DIR = 3;
endpackage

// File: rtl/pst_bit_tick.sv
module pst_bit_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_rate,
  output logic bit_en
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign bit_en = ~dbl_rate | phase_q;

  // R2: in double-rate operation no two adjacent clocks are both bit times
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_rate && bit_en) |=> (!bit_en || !dbl_rate));
endmodule

// File: rtl/pst_lock_fsm.sv
module pst_lock_fsm
  import pcm_sync_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] pos_next,
  output logic             lock_next,
  output logic             locked
);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  trk_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] period, max_len;
  logic             fs_q, edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fs_q <= 1'b0;
    else if (bit_en) fs_q <= fsync;
  end

  assign edge_w = bit_en & fsync & ~fs_q;
  assign period = {1'b0, cnt_q} + LEN_W'(1);

  always_comb begin
    case (mode)
      2'd0:    max_len = LEN_W'(BASE_LEN);
      2'd1:    max_len = LEN_W'(2 * BASE_LEN);
      default: max_len = LEN_W'(4 * BASE_LEN);
    endcase
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    len_n = len_q;
    if (bit_en) begin
      cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (edge_w) begin
            st_n  = ST_FIRST;
            cnt_n = '0;
          end
        end
        ST_FIRST: begin
          if (edge_w) begin
            cnt_n = '0;
            if (period <= max_len) begin
              len_n = period;
              st_n  = ST_VERIFY;
            end
          end else if (cnt_q == CNT_MAX) begin
            st_n = ST_IDLE;
          end
        end
        ST_VERIFY: begin
          if (edge_w) begin
            cnt_n = '0;
            if (period == len_q)       st_n  = ST_LOCK;
            else if (period <= max_len) len_n = period;
            else                        st_n  = ST_FIRST;
          end else if (period == len_q) begin
            st_n = ST_IDLE;
          end
        end
        default: begin
          if (edge_w) begin
            cnt_n = '0;
            if (period != len_q) st_n = ST_FIRST;
          end else if (period == len_q) begin
            st_n = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      len_q <= len_n;
    end
  end

  assign pos_q     = cnt_q;
  assign pos_next  = cnt_n;
  assign lock_next = (st_n == ST_LOCK);
  assign locked    = (st_q == ST_LOCK);

  // R4: lock is only ever entered on a sampled sync edge
  a_r4_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_LOCK) |-> $past(edge_w));

  // R3: a sync edge restarts the frame position at zero
  a_r3_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (cnt_q == '0));

  // R5: a stored length is never below two bits or above the largest limit
  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VERIFY || st_q == ST_LOCK) |->
      (len_q >= LEN_W'(2) && len_q <= LEN_W'(4 * BASE_LEN)));

  // R7: no edge at the due bit while locked drops lock
  a_r7_missing_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bit_en && !edge_w && period == len_q) |=> !locked);
endmodule

// File: rtl/pst_frame_marker.sv
module pst_frame_marker #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             lock_next,
  input  logic             locked,
  input  logic [CNT_W-1:0] pos_next,
  input  logic [CNT_W-1:0] offset,
  output logic             sof
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof <= 1'b0;
    else        sof <= bit_en & lock_next & (pos_next == offset);
  end

  // R10: a frame-start marker only appears while locked
  a_r10_sof_locked: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> locked);
endmodule

// File: rtl/pcm_sync_tracker.sv
module pcm_sync_tracker
  import pcm_sync_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [1:0]       mode,
  input  logic             dbl_rate,
  input  logic [CNT_W-1:0] off_in,
  input  logic [CNT_W-1:0] off_out,
  input  logic [CNT_W-1:0] off_ctl,
  output logic             sync_lost,
  output logic [2:0]       bit_cnt,
  output logic [CNT_W-4:0] slot_cnt,
  output logic             sof_in,
  output logic             sof_out,
  output logic             sof_ctl
);
  logic             bit_en, lock_next, locked;
  logic [CNT_W-1:0] pos_q, pos_next;
  logic [CNT_W-1:0] offs [NUM_DIR];
  logic [NUM_DIR-1:0] sofs;

  pst_bit_tick u_tick (
    .clk(clk), .rst_n(rst_n), .dbl_rate(dbl_rate), .bit_en(bit_en)
  );

  pst_lock_fsm #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .mode(mode),
    .pos_q(pos_q), .pos_next(pos_next), .lock_next(lock_next), .locked(locked)
  );

  assign offs[0] = off_in;
  assign offs[1] = off_out;
  assign offs[2] = off_ctl;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pst_frame_marker #(.CNT_W(CNT_W)) u_mark (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock_next(lock_next),
      .locked(locked), .pos_next(pos_next), .offset(offs[d]), .sof(sofs[d])
    );
  end

  assign sof_in    = sofs[0];
  assign sof_out   = sofs[1];
  assign sof_ctl   = sofs[2];
  assign sync_lost = ~locked;
  assign bit_cnt   = pos_q[2:0];
  assign slot_cnt  = pos_q[CNT_W-1:3];
endmodule

// File: tb/pcm_sync_tracker_tb.sv
module pcm_sync_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dbl_rate = 1'b0;
  logic [10:0] off_in = '0, off_out = '0, off_ctl = '0;
  logic        sync_lost, sof_in, sof_out, sof_ctl;
  logic [2:0]  bit_cnt;
  logic [7:0]  slot_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcm_sync_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode(mode), .dbl_rate(dbl_rate),
    .off_in(off_in), .off_out(off_out), .off_ctl(off_ctl),
    .sync_lost(sync_lost), .bit_cnt(bit_cnt), .slot_cnt(slot_cnt),
    .sof_in(sof_in), .sof_out(sof_out), .sof_ctl(sof_ctl)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic dbl);
    @(negedge clk);
    rst_n = 1'b0; fsync = 1'b0; mode = m; dbl_rate = dbl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk);
    fsync = v;
    repeat (dbl_rate ? 2 : 1) @(posedge clk);
    #1;
  endtask

  // chk: 0 none, 1 expect locked (markers and counters), 2 expect no markers
  task automatic frame(input int len, input int w, input int n, input int chk);
    for (int f = 0; f < n; f++) begin
      for (int p = 0; p < len; p++) begin
        drive_bit(p < w);
        if (chk == 1) begin
          check("R9 sof_in",  sof_in,  int'(p == int'(off_in)));
          check("R9 sof_out", sof_out, int'(p == int'(off_out)));
          check("R9 sof_ctl", sof_ctl, int'(p == int'(off_ctl)));
          if (p == 13) begin
            check("R3 bit_cnt", bit_cnt, 5);
            check("R3 slot_cnt", slot_cnt, 1);
          end
        end else if (chk == 2) begin
          check("R10 no markers", int'(sof_in | sof_out | sof_ctl), 0);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 sync_lost", sync_lost, 1);
    check("R1 markers", int'(sof_in | sof_out | sof_ctl), 0);
    check("R1 bit_cnt", bit_cnt, 0);
    check("R1 slot_cnt", slot_cnt, 0);
  endtask

  task automatic t_lock_offsets();
    do_reset(2'd0, 1'b0);
    off_in = 11'd0; off_out = 11'd5; off_ctl = 11'd17;
    frame(32, 1, 2, 2);
    check("R4 not locked after two edges", sync_lost, 1);
    frame(32, 1, 1, 1);
    check("R4 locked after third edge", sync_lost, 0);
    off_ctl = 11'd40;
    frame(32, 1, 2, 1);
    check("R9 stays locked", sync_lost, 0);
  endtask

  task automatic t_short_gap();
    do_reset(2'd0, 1'b0);
    off_in = 11'd0; off_out = 11'd15; off_ctl = 11'd3;
    frame(16, 15, 3, 0);
    check("R4 one-bit gap lock", sync_lost, 0);
    frame(16, 15, 1, 1);
    check("R4 one-bit gap held", sync_lost, 0);
  endtask

  task automatic t_early();
    do_reset(2'd0, 1'b0);
    off_in = 11'd0; off_out = 11'd2; off_ctl = 11'd9;
    frame(32, 1, 3, 0);
    frame(20, 1, 1, 1);
    check("R6 on-time edge keeps lock", sync_lost, 0);
    frame(32, 1, 1, 2);
    check("R6 early edge drops lock", sync_lost, 1);
    frame(32, 1, 1, 2);
    check("R8 second edge after loss", sync_lost, 1);
    frame(32, 1, 1, 0);
    check("R8 relock from early edge", sync_lost, 0);
  endtask

  task automatic t_missing();
    do_reset(2'd0, 1'b0);
    frame(32, 1, 3, 0);
    check("R7 locked before due bit", sync_lost, 0);
    drive_bit(1'b0);
    check("R7 missing edge drops lock", sync_lost, 1);
    frame(32, 1, 1, 2);
    check("R7 late edge no relock", sync_lost, 1);
    frame(32, 1, 1, 2);
    check("R8 still searching", sync_lost, 1);
    frame(32, 1, 1, 0);
    check("R8 relock after missing", sync_lost, 0);
  endtask

  task automatic t_modes();
    do_reset(2'd0, 1'b0);
    frame(300, 1, 4, 2);
    check("R5 mode0 rejects 300", sync_lost, 1);
    do_reset(2'd0, 1'b0);
    frame(257, 1, 4, 0);
    check("R5 mode0 rejects 257", sync_lost, 1);
    do_reset(2'd0, 1'b0);
    frame(256, 1, 3, 0);
    check("R5 mode0 accepts 256", sync_lost, 0);
    do_reset(2'd1, 1'b0);
    frame(300, 1, 3, 0);
    check("R5 mode1 accepts 300", sync_lost, 0);
    do_reset(2'd1, 1'b0);
    frame(600, 1, 4, 0);
    check("R5 mode1 rejects 600", sync_lost, 1);
    do_reset(2'd2, 1'b0);
    frame(600, 1, 3, 0);
    check("R5 mode2 accepts 600", sync_lost, 0);
  endtask

  task automatic t_double();
    do_reset(2'd0, 1'b1);
    frame(32, 1, 3, 0);
    check("R2 double-rate lock", sync_lost, 0);
    drive_bit(1'b1);
    check("R2 edge bit position", bit_cnt, 0);
    for (int i = 0; i < 8; i++) drive_bit(1'b0);
    check("R2 slot after 8 bits", slot_cnt, 1);
    check("R2 bit after 8 bits", bit_cnt, 0);
    for (int i = 0; i < 3; i++) drive_bit(1'b0);
    check("R3 bit after 11 bits", bit_cnt, 3);
    check("R2 still locked", sync_lost, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_offsets();
    t_short_gap();
    t_early();
    t_missing();
    t_modes();
    t_double();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule